// File: doc/BRIEF.md
# Prescaled Interval Timer

This block produces a periodic interrupt pulse from a free-running clock. A programmable prescale value sets how many clock cycles make up one count step. A 16-bit count register moves down by one on each step. When a step finds it at zero, it reloads from a separate period register and raises a one-cycle interrupt pulse. Counting goes straight on from the reloaded value, so the interval between pulses stays exact and never gains a lost cycle.

Software programs the block through a single write port. A 2-bit selector picks the prescale register, the count register, the period register or the control register. A small controller with two states, `ST_IDLE` (frozen) and `ST_RUN` (counting), follows the enable bit of the control register. The transition `ST_IDLE -> ST_RUN` is taken on a control write with bit 0 set. The transition `ST_RUN -> ST_IDLE` is taken on a control write with bit 0 clear. Any other cycle holds the state. The current count value is brought out on `count_out`, so the frozen and reloaded values can be observed.

Top module: `ivl_timer`

## Requirements
- R1: After reset, `count_out` is 0, `irq_pulse` is low, and the controller is in `ST_IDLE`, so nothing counts.
- R2: With `wr_en` high, `wr_sel` decodes as follows: 0 is the prescale value (`wr_data[7:0]`), 1 is the count register, 2 is the period register, and 3 is control (bit 0 is enable). A count write appears on `count_out` in the cycle after the write edge.
- R3: A prescale value N makes one count step every N+1 running cycles, which covers a range of 1 to 256 cycles per step.
- R4: Each count step lowers a non-zero count by exactly one.
- R5: A count step that finds the count at zero loads the period value into the count register at that edge and sets `irq_pulse` for the following cycle. In the cycle where `irq_pulse` is high, `count_out` shows the period value.
- R6: Counting resumes from the reloaded value with no idle cycle. With count C and period P written together with prescale N, the pulses come (C+1)(N+1) running cycles after enable, then every (P+1)(N+1) cycles after that.
- R7: In `ST_IDLE`, both the count and the prescale phase hold their values and no pulse is raised. Re-enabling continues from the frozen phase.
- R8: A count write reloads the prescale phase to its full value, and it overrides any count step in the same cycle.
- R9: `irq_pulse` is high for one cycle per expiry and is low in every other cycle.
- R10: A control write moves the controller (`ST_IDLE -> ST_RUN` on bit 0 set, `ST_RUN -> ST_IDLE` on bit 0 clear), and the new state governs counting from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 prescale, 1 count, 2 period, 3 control |
| wr_data | input | 16 | Write data |
| irq_pulse | output | 1 | One-cycle expiry pulse |
| count_out | output | 16 | Current count register value |

## Verification
The assertions assume at most one register write per cycle, carried by `wr_en` and `wr_sel`. They also assume that `wr_data` is stable around the clock edge. The bench changes every input only on the falling edge and issues each write as one strobe of a single cycle, so it keeps within both assumptions. The cycle-exact interval checks assume that no writes happen while a measurement window runs. For this reason the bench programs each configuration while the timer is idle and then only observes.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
    typedef enum logic [1:0] {
        SEL_PRESCALE = 2'd0,
        SEL_COUNT    = 2'd1,
        SEL_PERIOD   = 2'd2,
        SEL_CONTROL  = 2'd3
    } wsel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tstate_e;
endpackage

// File: rtl/ivl_timer_ctrl.sv
module ivl_timer_ctrl
    import ivl_timer_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  wsel_e            wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             running,
    output logic             cnt_load,
    output logic [PRE_W-1:0] pre_val,
    output logic [CNT_W-1:0] per_val
);
    tstate_e          state_q, state_d;
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] per_q;
    logic             ctl_wr;

    assign ctl_wr = wr_en && (wr_sel == SEL_CONTROL);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ctl_wr && wr_data[0])  state_d = ST_RUN;
            ST_RUN:  if (ctl_wr && !wr_data[0]) state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        running  = 1'b0;
        unique case (state_q)
            ST_IDLE: running = 1'b0;
            ST_RUN:  running = 1'b1;
        endcase
        cnt_load = wr_en && (wr_sel == SEL_COUNT);
        pre_val  = pre_q;
        per_val  = per_q;
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            per_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_PRESCALE) pre_q <= wr_data[PRE_W-1:0];
            if (wr_sel == SEL_PERIOD)   per_q <= wr_data;
        end
    end
endmodule

// File: rtl/ivl_timer_prescale.sv
module ivl_timer_prescale #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] pre_val,
    output logic             tick
);
    logic [PRE_W-1:0] phase_q;

    assign tick = run && !restart && (phase_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)               phase_q <= '0;
        else if (restart)         phase_q <= pre_val;
        else if (run) begin
            if (phase_q == '0)    phase_q <= pre_val;
            else                  phase_q <= phase_q - 1'b1;
        end
    end
endmodule

// File: rtl/ivl_timer_counter.sv
module ivl_timer_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] per_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic at_zero;

    assign at_zero = (count == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            expire <= 1'b0;
        end else begin
            expire <= step && !load && at_zero;
            if (load)         count <= load_val;
            else if (step) begin
                if (at_zero)  count <= per_val;
                else          count <= count - 1'b1;
            end
        end
    end
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
    import ivl_timer_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             irq_pulse,
    output logic [CNT_W-1:0] count_out
);
    logic             running;
    logic             cnt_load;
    logic             tick;
    logic [PRE_W-1:0] pre_val;
    logic [CNT_W-1:0] period_q;

    ivl_timer_ctrl #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wsel_e'(wr_sel)),
        .wr_data  (wr_data),
        .running  (running),
        .cnt_load (cnt_load),
        .pre_val  (pre_val),
        .per_val  (period_q)
    );

    ivl_timer_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .restart (cnt_load),
        .pre_val (pre_val),
        .tick    (tick)
    );

    ivl_timer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (tick),
        .load     (cnt_load),
        .load_val (wr_data),
        .per_val  (period_q),
        .count    (count_out),
        .expire   (irq_pulse)
    );
endmodule

// File: rtl/ivl_timer_chk.sv
module ivl_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [CNT_W-1:0] wr_data,
    input logic             running,
    input logic [CNT_W-1:0] period_q,
    input logic             irq_pulse,
    input logic [CNT_W-1:0] count_out
);
    logic cw;
    assign cw = wr_en && (wr_sel == 2'd1);

    p_count_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cw |=> (count_out == $past(wr_data)));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cw) |=> ($stable(count_out) || irq_pulse ||
                              (count_out == $past(count_out) - 1'b1)));

    p_irq_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> ($past(count_out) == '0));

    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (count_out == $past(period_q)));

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cw) |=> ($stable(count_out) && !irq_pulse));
endmodule

bind ivl_timer ivl_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .running   (running),
    .period_q  (period_q),
    .irq_pulse (irq_pulse),
    .count_out (count_out)
);

// File: tb/ivl_timer_tb.sv
`timescale 1ns/1ps
module ivl_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        irq_pulse;
    logic [15:0] count_out;
    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ivl_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .irq_pulse (irq_pulse),
        .count_out (count_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one write strobe; returns at the falling edge after the write edge
    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        wr_sel  = sel;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    initial begin
        #(8 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int pres[5] = '{0, 1, 2, 5, 255};
        int pers[3] = '{0, 1, 3};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 count after reset", count_out, 0);
        chk("R1 irq after reset", irq_pulse, 0);

        // R2 count write while idle; R7 idle freeze
        wr(2'd1, 16'h1234);
        chk("R2 count write", count_out, 16'h1234);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk("R7 idle count hold", count_out, 16'h1234);
            chk("R7 idle no irq", irq_pulse, 0);
        end

        // R10 enable edge does not count; R4 decrement by one per step
        wr(2'd0, 16'd0);
        wr(2'd2, 16'd100);
        wr(2'd1, 16'd10);
        wr(2'd3, 16'd1);
        chk("R10 no step on enable edge", count_out, 10);
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            chk("R4 decrement", count_out, 10 - k);
        end

        // R3 R5 R6 R9: sweep prescale and period
        foreach (pres[i]) begin
            foreach (pers[j]) begin
                int iv;
                wr(2'd3, 16'd0);
                wr(2'd0, 16'(pres[i]));
                wr(2'd2, 16'(pers[j]));
                wr(2'd1, 16'(pers[j]));
                wr(2'd3, 16'd1);
                iv = (pers[j] + 1) * (pres[i] + 1);
                for (int k = 1; k <= 3 * iv; k++) begin
                    @(negedge clk);
                    if (k % iv == 0) begin
                        chk("R3 R6 expiry pulse", irq_pulse, 1);
                        chk("R5 reload value", count_out, pers[j]);
                    end else begin
                        chk("R9 no extra pulse", irq_pulse, 0);
                    end
                end
            end
        end

        // R7 freeze mid-run and resume phase; R10 disable transition
        wr(2'd3, 16'd0);
        wr(2'd0, 16'd3);
        wr(2'd2, 16'd9);
        wr(2'd1, 16'd9);
        wr(2'd3, 16'd1);
        repeat (5) @(negedge clk);
        wr(2'd3, 16'd0);            // 6 running edges so far
        chk("R7 frozen value", count_out, 8);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk("R10 idle hold", count_out, 8);
            chk("R7 no irq idle", irq_pulse, 0);
        end
        wr(2'd3, 16'd1);
        for (int k = 7; k <= 40; k++) begin
            @(negedge clk);
            chk("R7 resumed phase", irq_pulse, (k == 40) ? 1 : 0);
        end

        // R8: count write restarts prescale phase
        wr(2'd3, 16'd0);
        wr(2'd2, 16'd50);
        wr(2'd1, 16'd5);
        wr(2'd3, 16'd1);
        repeat (2) @(negedge clk);
        wr(2'd1, 16'd5);
        chk("R8 count write while running", count_out, 5);
        for (int k = 1; k <= 24; k++) begin
            @(negedge clk);
            chk("R8 restarted phase", irq_pulse, (k == 24) ? 1 : 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule